// File: doc/BRIEF.md
# UART FIFO Pair with Trigger Levels

This block is the buffering core of a serial port. Completed characters from a receive shift register enter a 64-entry receive queue, and the host drains that queue through a read port. In the other direction, the host fills a 64-entry transmit queue, and a transmit shift register takes bytes from it one at a time. The serial framing, baud timing and host bus are outside the block. The shift registers appear only as single-cycle byte strobes.

A write-only control byte configures the block. Bit 0 turns queue mode on or off. Bit 1 empties the receive queue and bit 2 empties the transmit queue; both clear bits act once and are not stored. Bits 7:6 pick a receive threshold, counted in characters held. Bits 5:4 pick a transmit threshold, counted in free spaces. The transmit threshold field is only written while a separate enhanced-feature input is high. With queue mode off, the receive side shrinks to a single holding byte, while the transmit side keeps its full queue. Each side reports its fill level and a threshold flag. A sticky overrun flag records lost receive characters.

Top module: `uart_fifo_core`

## Requirements
- R1: After a synchronous reset, both levels read 0, rx_trig and rx_ovr are 0, tx_trig is 1 (64 free spaces), queue mode is off and both threshold fields are 00.
- R2: Bytes leave each queue in arrival order. rx_rdata holds the popped byte from the clock edge where rx_rd is sampled high, and tx_byte does the same for tx_take.
- R3: In queue mode, a character pushed while the receive queue holds 64 entries is dropped and the stored entries are kept. rx_ovr then rises and stays high until ovr_rd is pulsed.
- R4: Control bits 7:6 set the receive threshold: 00=8, 01=16, 10=56, 11=60 characters. rx_trig is 1 while rx_level is at or above that threshold.
- R5: Control bits 5:4 set the transmit threshold: 00=8, 01=16, 10=32, 11=56 free spaces. tx_trig is 1 while 64 minus tx_level is at or above that threshold.
- R6: A control write with enh_en low leaves the transmit threshold field unchanged, while the other fields still update.
- R7: A control write with bit 1 set gives rx_level 0 two edges after the write, and bit 2 does the same for tx_level. Neither bit touches the other queue or the byte already handed to the transmit shift register. Neither bit is stored.
- R8: Control bit 0 selects queue mode. A write that changes bit 0 empties both queues.
- R9: With queue mode off, rx_level never exceeds 1. A character arriving while a byte is unread replaces that byte and sets rx_ovr. The transmit queue still holds up to 64 bytes.
- R10: A push and a pop in the same cycle leave the level unchanged, and a pop of an empty queue changes nothing.
- R11: A host write to a transmit queue that holds 64 bytes is lost, and the queued bytes stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte (bit 3 unused) |
| enh_en | input | 1 | Enhanced-feature enable; gates bits 5:4 |
| rx_push | input | 1 | Receive shift register delivers a character |
| rx_push_data | input | 8 | Received character |
| rx_rd | input | 1 | Host pops the receive queue |
| rx_rdata | output | 8 | Popped receive byte |
| rx_level | output | 7 | Characters held in the receive queue (0..64) |
| rx_trig | output | 1 | Receive threshold reached |
| rx_ovr | output | 1 | Sticky receive overrun |
| ovr_rd | input | 1 | Host read of the overrun status; clears rx_ovr |
| tx_wr | input | 1 | Host writes a byte to the transmit queue |
| tx_wdata | input | 8 | Byte to transmit |
| tx_take | input | 1 | Transmit shift register takes a byte |
| tx_byte | output | 8 | Byte handed to the transmit shift register |
| tx_avail | output | 1 | Transmit queue is not empty |
| tx_level | output | 7 | Bytes held in the transmit queue (0..64) |
| tx_trig | output | 1 | Transmit free-space threshold reached |

## Verification
The hardest state to reach from the ports is a receive queue at full depth, one character past the drop point, where the contents must then be checked to be unchanged. The stimulus gets there by pushing 64 numbered bytes and one marker byte, then reading back all 64 to confirm that the marker never entered. The single-byte overwrite is reached only after a control write has turned queue mode off and cleared both queues. The bench therefore leaves bytes pending in the transmit queue before that write, to show the mode change empties it. The threshold boundaries come from a vector table that places each level one below and exactly at each encoded threshold. That table also covers a gated transmit-field write.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  // control byte bit positions (decoded by the control register)
  localparam int CTL_EN_BIT    = 0;
  localparam int CTL_RXCLR_BIT = 1;
  localparam int CTL_TXCLR_BIT = 2;
  localparam int CTL_TXSEL_LO  = 4;
  localparam int CTL_RXSEL_LO  = 6;

  // receive threshold in characters held
  function automatic logic [7:0] rx_thresh(input logic [1:0] sel);
    case (sel)
      2'b00:   return 8'd8;
      2'b01:   return 8'd16;
      2'b10:   return 8'd56;
      default: return 8'd60;
    endcase
  endfunction

  // transmit threshold in free spaces
  function automatic logic [7:0] tx_thresh(input logic [1:0] sel);
    case (sel)
      2'b00:   return 8'd8;
      2'b01:   return 8'd16;
      2'b10:   return 8'd32;
      default: return 8'd56;
    endcase
  endfunction

endpackage

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       enh,
  output logic       fifo_en,
  output logic [1:0] rx_sel,
  output logic [1:0] tx_sel,
  output logic       rx_clr,
  output logic       tx_clr
);

  logic mode_flip;
  logic rsvd_unused;

  assign mode_flip   = wdata[CTL_EN_BIT] != fifo_en;
  assign rsvd_unused = wdata[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en <= 1'b0;
      rx_sel  <= 2'b00;
      tx_sel  <= 2'b00;
      rx_clr  <= 1'b0;
      tx_clr  <= 1'b0;
    end else begin
      rx_clr <= wr && (wdata[CTL_RXCLR_BIT] || mode_flip);
      tx_clr <= wr && (wdata[CTL_TXCLR_BIT] || mode_flip);
      if (wr) begin
        fifo_en <= wdata[CTL_EN_BIT];
        rx_sel  <= wdata[CTL_RXSEL_LO +: 2];
        if (enh) tx_sel <= wdata[CTL_TXSEL_LO +: 2];
      end
    end
  end

  // R6: gated field keeps its value
  a_r6_tx_sel_hold: assert property (@(posedge clk) disable iff (rst)
    wr && !enh |=> tx_sel == $past(tx_sel));

  // R7: clear strobes are single pulses
  a_r7_rx_clr_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_clr && !wr |=> !rx_clr);
  a_r7_tx_clr_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_clr && !wr |=> !tx_clr);

endmodule

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter  int DW    = 8,
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          single,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count,
  output logic          drop
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr, waddr, raddr;
  logic          is_empty, is_full, do_push, do_pop;
  logic [CW-1:0] count_nx;

  assign is_empty = count == '0;
  assign is_full  = count == FULL_C;
  assign do_pop   = pop && !is_empty && !clr;
  assign waddr    = single ? '0 : wptr;
  assign raddr    = single ? '0 : rptr;

  always_comb begin
    if (clr) begin
      do_push = 1'b0;
      drop    = 1'b0;
    end else if (single) begin
      do_push = push;
      drop    = push && !is_empty && !do_pop;
    end else begin
      do_push = push && (!is_full || do_pop);
      drop    = push && is_full && !do_pop;
    end
  end

  always_comb begin
    if (clr)         count_nx = '0;
    else if (single) count_nx = do_push ? CW'(1) : (do_pop ? '0 : count);
    else             count_nx = count + CW'(do_push) - CW'(do_pop);
  end

  // storage: no reset, one write and one registered read port
  always_ff @(posedge clk) begin
    if (do_push) mem[waddr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (do_pop) pop_data <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      count <= count_nx;
      if (!single) begin
        if (do_push) wptr <= wptr + AW'(1);
        if (do_pop)  rptr <= rptr + AW'(1);
      end
    end
  end

  // R3: level never passes the depth; a full queue stays full on a lone push
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_C);
  a_r3_full_kept: assert property (@(posedge clk) disable iff (rst)
    !single && push && !pop && is_full && !clr |=> count == FULL_C);

  // R7: clear empties the queue
  a_r7_clear_empty: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0);

  // R10: push with pop keeps the level; pop of empty does nothing
  a_r10_push_pop_level: assert property (@(posedge clk) disable iff (rst)
    push && pop && !is_empty && !clr |=> count == $past(count));
  a_r10_empty_pop: assert property (@(posedge clk) disable iff (rst)
    pop && !push && is_empty && !clr |=> count == '0);

endmodule

// File: rtl/uart_fifo_core.sv
module uart_fifo_core
  import uart_fifo_pkg::*;
#(
  parameter  int DW    = 8,
  parameter  int DEPTH = 64,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  input  logic          enh_en,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_push_data,
  input  logic          rx_rd,
  output logic [DW-1:0] rx_rdata,
  output logic [CW-1:0] rx_level,
  output logic          rx_trig,
  output logic          rx_ovr,
  input  logic          ovr_rd,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_wdata,
  input  logic          tx_take,
  output logic [DW-1:0] tx_byte,
  output logic          tx_avail,
  output logic [CW-1:0] tx_level,
  output logic          tx_trig
);

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic          fifo_en, rx_clr, tx_clr, rx_drop, tx_drop;
  logic [1:0]    rx_sel, tx_sel;
  logic [CW-1:0] rx_cnt, tx_cnt, tx_free;

  uart_fifo_ctl u_ctl (
    .clk    (clk),
    .rst    (rst),
    .wr     (ctl_wr),
    .wdata  (ctl_wdata),
    .enh    (enh_en),
    .fifo_en(fifo_en),
    .rx_sel (rx_sel),
    .tx_sel (tx_sel),
    .rx_clr (rx_clr),
    .tx_clr (tx_clr)
  );

  uart_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_q (
    .clk      (clk),
    .rst      (rst),
    .clr      (rx_clr),
    .single   (!fifo_en),
    .push     (rx_push),
    .push_data(rx_push_data),
    .pop      (rx_rd),
    .pop_data (rx_rdata),
    .count    (rx_cnt),
    .drop     (rx_drop)
  );

  uart_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_q (
    .clk      (clk),
    .rst      (rst),
    .clr      (tx_clr),
    .single   (1'b0),
    .push     (tx_wr),
    .push_data(tx_wdata),
    .pop      (tx_take),
    .pop_data (tx_byte),
    .count    (tx_cnt),
    .drop     (tx_drop)
  );

  // sticky overrun: a new loss wins over a same-cycle status read
  always_ff @(posedge clk) begin
    if (rst)          rx_ovr <= 1'b0;
    else if (rx_drop) rx_ovr <= 1'b1;
    else if (ovr_rd)  rx_ovr <= 1'b0;
  end

  assign tx_free  = DEPTH_C - tx_cnt;
  assign rx_level = rx_cnt;
  assign tx_level = tx_cnt;
  assign tx_avail = tx_cnt != '0;
  assign rx_trig  = rx_cnt  >= CW'(rx_thresh(rx_sel));
  assign tx_trig  = tx_free >= CW'(tx_thresh(tx_sel));

  // R3: overrun holds until the status is read
  a_r3_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    rx_ovr && !ovr_rd |=> rx_ovr);

  // R9: one-byte receive holding when queue mode is off
  a_r9_single_depth: assert property (@(posedge clk) disable iff (rst)
    !fifo_en && $past(!fifo_en) |-> rx_cnt <= CW'(1));

  // R11: a lost host write only happens at full depth, which is kept
  a_r11_tx_lost: assert property (@(posedge clk) disable iff (rst)
    tx_drop |=> tx_cnt == DEPTH_C);

endmodule

// File: tb/test_uart_fifo_core.sv
`timescale 1ns/1ps
module test_uart_fifo_core;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 0, enh_en = 0, rx_push = 0, rx_rd = 0, ovr_rd = 0;
  logic       tx_wr = 0, tx_take = 0;
  logic [7:0] ctl_wdata = 0, rx_push_data = 0, tx_wdata = 0;
  logic [7:0] rx_rdata, tx_byte;
  logic [6:0] rx_level, tx_level;
  logic       rx_trig, rx_ovr, tx_avail, tx_trig;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_fifo_core i_uart_fifo_core (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .enh_en(enh_en),
    .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_rd(rx_rd),
    .rx_rdata(rx_rdata), .rx_level(rx_level), .rx_trig(rx_trig),
    .rx_ovr(rx_ovr), .ovr_rd(ovr_rd), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
    .tx_take(tx_take), .tx_byte(tx_byte), .tx_avail(tx_avail),
    .tx_level(tx_level), .tx_trig(tx_trig)
  );

  // row: rx_sel[20:19] tx_sel[18:17] enh[16] rx_fill[15:9] tx_fill[8:2] exp_rx[1] exp_tx[0]
  localparam logic [20:0] VEC [10] = '{
    {2'b00, 2'b00, 1'b1, 7'd7,  7'd56, 1'b0, 1'b1},
    {2'b00, 2'b00, 1'b1, 7'd8,  7'd57, 1'b1, 1'b0},
    {2'b01, 2'b01, 1'b1, 7'd15, 7'd48, 1'b0, 1'b1},
    {2'b01, 2'b01, 1'b1, 7'd16, 7'd49, 1'b1, 1'b0},
    {2'b10, 2'b10, 1'b1, 7'd55, 7'd32, 1'b0, 1'b1},
    {2'b10, 2'b10, 1'b1, 7'd56, 7'd33, 1'b1, 1'b0},
    {2'b11, 2'b11, 1'b1, 7'd59, 7'd8,  1'b0, 1'b1},
    {2'b11, 2'b11, 1'b1, 7'd60, 7'd9,  1'b1, 1'b0},
    {2'b00, 2'b00, 1'b0, 7'd8,  7'd8,  1'b1, 1'b1},
    {2'b00, 2'b00, 1'b0, 7'd8,  7'd9,  1'b1, 1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr_ctl(input logic [7:0] v, input logic e);
    ctl_wr = 1; ctl_wdata = v; enh_en = e;
    @(negedge clk);
    ctl_wr = 0; enh_en = 0;
    @(negedge clk);
  endtask

  task automatic push_rx(input logic [7:0] d);
    rx_push = 1; rx_push_data = d;
    @(negedge clk);
    rx_push = 0;
  endtask

  task automatic rd_rx();
    rx_rd = 1;
    @(negedge clk);
    rx_rd = 0;
  endtask

  task automatic push_pop_rx(input logic [7:0] d);
    rx_push = 1; rx_rd = 1; rx_push_data = d;
    @(negedge clk);
    rx_push = 0; rx_rd = 0;
  endtask

  task automatic wr_tx(input logic [7:0] d);
    tx_wr = 1; tx_wdata = d;
    @(negedge clk);
    tx_wr = 0;
  endtask

  task automatic take_tx();
    tx_take = 1;
    @(negedge clk);
    tx_take = 0;
  endtask

  task automatic pulse_ovr_rd();
    ovr_rd = 1;
    @(negedge clk);
    ovr_rd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    check("R1 rx_level", rx_level, 0);
    check("R1 tx_level", tx_level, 0);
    check("R1 rx_trig", rx_trig, 0);
    check("R1 tx_trig", tx_trig, 1);
    check("R1 rx_ovr", rx_ovr, 0);
    check("R1 tx_avail", tx_avail, 0);

    // R4 R5 R6 threshold table, queue mode on
    wr_ctl(8'h01, 1'b1);
    for (int i = 0; i < 10; i++) begin
      logic [20:0] v;
      v = VEC[i];
      wr_ctl({v[20:19], v[18:17], 4'b0111}, v[16]);
      for (int k = 0; k < int'(v[15:9]); k++) push_rx(8'(k));
      for (int k = 0; k < int'(v[8:2]); k++) wr_tx(8'(k));
      check($sformatf("R4 row %0d rx_level", i), rx_level, int'(v[15:9]));
      check($sformatf("R4 row %0d rx_trig", i), rx_trig, v[1]);
      check($sformatf("R5 R6 row %0d tx_trig", i), tx_trig, v[0]);
    end

    // R3 R2 receive overflow at full depth
    wr_ctl(8'h07, 1'b0);
    check("R7 rx cleared", rx_level, 0);
    check("R3 ovr before", rx_ovr, 0);
    for (int k = 0; k < 64; k++) push_rx(8'(k + 3));
    push_rx(8'hEE);
    check("R3 level at full", rx_level, 64);
    check("R3 ovr set", rx_ovr, 1);
    @(negedge clk);
    check("R3 ovr sticky", rx_ovr, 1);
    for (int k = 0; k < 64; k++) begin
      rd_rx();
      check("R2 R3 rx order", rx_rdata, (k + 3) & 8'hFF);
    end
    check("R3 drained", rx_level, 0);
    pulse_ovr_rd();
    check("R3 ovr cleared", rx_ovr, 0);

    // R10 simultaneous push and pop, empty pop
    push_rx(8'h10); push_rx(8'h11); push_rx(8'h12);
    push_pop_rx(8'h13);
    check("R10 level kept", rx_level, 3);
    check("R10 popped data", rx_rdata, 8'h10);
    rd_rx(); check("R2 rx 11", rx_rdata, 8'h11);
    rd_rx(); check("R2 rx 12", rx_rdata, 8'h12);
    rd_rx(); check("R2 rx 13", rx_rdata, 8'h13);
    rd_rx();
    check("R10 empty pop level", rx_level, 0);
    check("R10 empty pop data", rx_rdata, 8'h13);

    // R11 transmit write when full
    for (int k = 0; k < 64; k++) wr_tx(8'(k) ^ 8'h5A);
    wr_tx(8'hFF);
    check("R11 tx level full", tx_level, 64);
    check("R5 tx_trig at zero free", tx_trig, 0);
    take_tx();
    check("R11 R2 first tx", tx_byte, 8'h5A);
    check("R11 tx level", tx_level, 63);

    // R7 independent clears, shift byte untouched
    for (int k = 0; k < 5; k++) push_rx(8'(k));
    take_tx();
    check("R2 second tx", tx_byte, 8'h5B);
    wr_ctl(8'h03, 1'b0);
    check("R7 rx clear", rx_level, 0);
    check("R7 tx untouched", tx_level, 62);
    check("R7 tx_byte kept", tx_byte, 8'h5B);
    wr_ctl(8'h05, 1'b0);
    check("R7 tx clear", tx_level, 0);
    check("R7 tx_byte kept 2", tx_byte, 8'h5B);
    check("R7 tx_avail", tx_avail, 0);
    @(negedge clk);
    check("R7 no repeat clear", tx_level, 0);
    wr_tx(8'h77);
    @(negedge clk);
    check("R7 clear not stored", tx_level, 1);

    // R8 mode change empties both; R9 single byte receive
    wr_tx(8'h78);
    push_rx(8'h44);
    wr_ctl(8'h00, 1'b0);
    check("R8 tx emptied", tx_level, 0);
    check("R8 rx emptied", rx_level, 0);
    push_rx(8'hA1);
    push_rx(8'hA2);
    check("R9 single level", rx_level, 1);
    check("R9 overwrite ovr", rx_ovr, 1);
    pulse_ovr_rd();
    check("R9 ovr cleared", rx_ovr, 0);
    rd_rx();
    check("R9 newest kept", rx_rdata, 8'hA2);
    check("R9 empty after read", rx_level, 0);
    wr_tx(8'h31); wr_tx(8'h32); wr_tx(8'h33);
    check("R9 tx still queued", tx_level, 3);
    take_tx(); check("R9 tx 31", tx_byte, 8'h31);
    take_tx(); check("R9 tx 32", tx_byte, 8'h32);
    take_tx(); check("R9 tx 33", tx_byte, 8'h33);
    push_rx(8'h55);
    wr_ctl(8'h01, 1'b0);
    check("R8 enable empties rx", rx_level, 0);

    // R1 reset in mid-run
    push_rx(8'h66); wr_tx(8'h67);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1 rx_level again", rx_level, 0);
    check("R1 tx_level again", tx_level, 0);
    check("R1 tx_trig again", tx_trig, 1);
    push_rx(8'h01); push_rx(8'h02);
    check("R1 mode off after reset", rx_level, 1);

    finish_run();
  end

endmodule